// File: doc/BRIEF.md
# Staged Reset Release Sequencer

This block brings a chip out of reset in a fixed order once reset assertion is over. A one-cycle start pulse begins a pass, and a flag sampled with that pulse marks the pass as cold or warm. The sequencer first frees the interconnect. It then waits a fixed number of cycles before freeing the miscellaneous modules. On a cold pass it also frees the debug logic at that point. Next it stops the clocks of both processor cores and frees the processor resets while those clocks are stopped. Finally it restarts the core clocks and marks the pass complete with a one-cycle done pulse.

Peripheral resets are held until software lets them go. Each peripheral has a release bit. A peripheral leaves reset only when the last pass is complete and its bit is set. A start pulse that arrives while a pass is running is dropped. All four stage delays are parameters, and one down-counter times every stage.

Top module: `rst_release_seq`

## Requirements
- R1: While rst_n is low, and after it, all reset outputs (active low) read 0. cpu_clkoff_o reads 2'b00, done_o reads 0 and every periph_rst_n_o bit reads 0.
- R2: Suppose start_i is 1 at a clock edge while the block is idle. From that edge on, l3_rst_n_o reads 1. misc_rst_n_o, mpu_rst_n_o and every periph_rst_n_o bit read 0.
- R3: misc_rst_n_o goes to 1 exactly D_MISC (default 100) cycles after the edge that freed the interconnect.
- R4: On a cold pass (cold_i = 1 with the start pulse), dbg_rst_n_o is driven to 0 at the start edge. It goes to 1 at the same edge as misc_rst_n_o.
- R5: On a warm pass (cold_i = 0 with the start pulse), dbg_rst_n_o keeps the value it had before the pass for the whole pass.
- R6: cpu_clkoff_o becomes 2'b11 exactly D_GATE (default 200) cycles after the miscellaneous release.
- R7: mpu_rst_n_o goes to 1 exactly D_MPU (default 32) cycles after the clocks stop, and never while cpu_clkoff_o is not 2'b11.
- R8: cpu_clkoff_o returns to 2'b00 exactly D_UNGATE (default 32) cycles after the processor release. At that same edge done_o is 1 for exactly one cycle.
- R9: periph_rst_n_o[i] equals periph_rel_i[i] once a pass has completed, and follows that input combinationally. It stays 0 from a start edge until the end of that pass.
- R10: A start_i pulse sampled while a pass is running is ignored. This includes the final edge of the pass. Output values and stage timing are unchanged.
- R11: The two bits of cpu_clkoff_o are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pulse that begins a release pass |
| cold_i | input | 1 | 1 = cold pass, 0 = warm pass, sampled with start_i |
| periph_rel_i | input | N_PERIPH | Software release bit per peripheral |
| l3_rst_n_o | output | 1 | Interconnect reset, active low |
| misc_rst_n_o | output | 1 | Miscellaneous module reset, active low |
| dbg_rst_n_o | output | 1 | Debug reset, active low |
| mpu_rst_n_o | output | 1 | Processor reset, active low |
| cpu_clkoff_o | output | 2 | Clock stop for core 0 (bit 0) and core 1 (bit 1) |
| periph_rst_n_o | output | N_PERIPH | Peripheral resets, active low |
| done_o | output | 1 | One-cycle pulse when a pass finishes |

## Verification
Two events can fall on the same edge: the last stage ends (clocks restart, done pulses) and a new start pulse is sampled. The bench provokes this by driving start_i high for exactly that final edge. Two cycles later it expects misc_rst_n_o still at 1, the clocks running, a single done pulse, and peripherals released per their bits; a restart would instead pull the miscellaneous and peripheral resets low. A start pulse in the middle of a pass, with the cold flag flipped, is judged the same way. The stage edges that follow must keep their original cycle numbers.

// File: rtl/rrs_pkg.sv
// Shared types for the staged reset release sequencer.
// Assumes: one state per timed stage plus idle.
package rrs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_WAIT_MISC   = 3'd1,
        ST_WAIT_GATE   = 3'd2,
        ST_WAIT_MPU    = 3'd3,
        ST_WAIT_UNGATE = 3'd4
    } rrs_state_e;
endpackage

// File: rtl/rrs_stage_timer.sv
// Down-counter shared by all stages. A load sets the count to the stage delay.
// expire_o is high while the count is 1, so the next stage action happens
// exactly DELAY edges after the load edge.
// Assumes: every loaded value is at least 1.
module rrs_stage_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Flag the last cycle of a stage.
    assign expire_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/rrs_ctrl.sv
// Stage controller. It steps idle -> misc -> gate -> mpu -> ungate -> idle,
// reloads the shared timer on every transition and drives the registered
// reset and clock-stop outputs.
// Assumes: start_i is ignored outside idle; the cold flag is captured with start.
module rrs_ctrl
    import rrs_pkg::*;
#(
    parameter int unsigned D_MISC   = 100,
    parameter int unsigned D_GATE   = 200,
    parameter int unsigned D_MPU    = 32,
    parameter int unsigned D_UNGATE = 32,
    parameter int unsigned CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cold_i,
    input  logic             expire_i,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             l3_rst_n_o,
    output logic             misc_rst_n_o,
    output logic             dbg_rst_n_o,
    output logic             mpu_rst_n_o,
    output logic [1:0]       cpu_clkoff_o,
    output logic             done_o,
    output logic             complete_o
);
    localparam logic [CNT_W-1:0] LV_MISC   = CNT_W'(D_MISC);
    localparam logic [CNT_W-1:0] LV_GATE   = CNT_W'(D_GATE);
    localparam logic [CNT_W-1:0] LV_MPU    = CNT_W'(D_MPU);
    localparam logic [CNT_W-1:0] LV_UNGATE = CNT_W'(D_UNGATE);

    rrs_state_e state_q, state_d;
    logic       cold_q;
    logic       begin_pass;
    logic       stage_end;

    assign begin_pass = (state_q == ST_IDLE) && start_i;
    assign stage_end  = (state_q != ST_IDLE) && expire_i;

    // Next state and timer reload value.
    always_comb begin
        state_d    = state_q;
        load_o     = 1'b0;
        load_val_o = LV_MISC;
        if (begin_pass) begin
            state_d    = ST_WAIT_MISC;
            load_o     = 1'b1;
            load_val_o = LV_MISC;
        end else if (stage_end) begin
            load_o = 1'b1;
            unique case (state_q)
                ST_WAIT_MISC: begin
                    state_d    = ST_WAIT_GATE;
                    load_val_o = LV_GATE;
                end
                ST_WAIT_GATE: begin
                    state_d    = ST_WAIT_MPU;
                    load_val_o = LV_MPU;
                end
                ST_WAIT_MPU: begin
                    state_d    = ST_WAIT_UNGATE;
                    load_val_o = LV_UNGATE;
                end
                default: begin
                    state_d = ST_IDLE;
                    load_o  = 1'b0;
                end
            endcase
        end
    end

    // State register and captured pass type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cold_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            if (begin_pass) cold_q <= cold_i;
        end
    end

    // Registered reset, clock-stop, done and completion outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l3_rst_n_o   <= 1'b0;
            misc_rst_n_o <= 1'b0;
            dbg_rst_n_o  <= 1'b0;
            mpu_rst_n_o  <= 1'b0;
            cpu_clkoff_o <= 2'b00;
            done_o       <= 1'b0;
            complete_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (begin_pass) begin
                l3_rst_n_o   <= 1'b1;
                misc_rst_n_o <= 1'b0;
                mpu_rst_n_o  <= 1'b0;
                cpu_clkoff_o <= 2'b00;
                complete_o   <= 1'b0;
                if (cold_i) dbg_rst_n_o <= 1'b0;
            end else if (stage_end) begin
                unique case (state_q)
                    ST_WAIT_MISC: begin
                        misc_rst_n_o <= 1'b1;
                        if (cold_q) dbg_rst_n_o <= 1'b1;
                    end
                    ST_WAIT_GATE:   cpu_clkoff_o <= 2'b11;
                    ST_WAIT_MPU:    mpu_rst_n_o  <= 1'b1;
                    default: begin
                        cpu_clkoff_o <= 2'b00;
                        done_o       <= 1'b1;
                        complete_o   <= 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/rrs_periph_gate.sv
// Peripheral reset gating. Each peripheral leaves reset only after a pass has
// completed and while its software release bit is set.
// Assumes: release bits are already synchronous to clk.
module rrs_periph_gate #(
    parameter int unsigned N_PERIPH = 4
) (
    input  logic                complete_i,
    input  logic [N_PERIPH-1:0] rel_i,
    output logic [N_PERIPH-1:0] rst_n_o
);
    for (genvar g = 0; g < N_PERIPH; g++) begin : g_periph
        // One gate per peripheral.
        assign rst_n_o[g] = complete_i & rel_i[g];
    end
endmodule

// File: rtl/rst_release_seq.sv
// Top of the staged reset release sequencer: controller, shared stage timer
// and peripheral gating.
// Assumes: every stage delay is at least 1 cycle.
module rst_release_seq #(
    parameter int unsigned D_MISC   = 100,
    parameter int unsigned D_GATE   = 200,
    parameter int unsigned D_MPU    = 32,
    parameter int unsigned D_UNGATE = 32,
    parameter int unsigned N_PERIPH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cold_i,
    input  logic [N_PERIPH-1:0] periph_rel_i,
    output logic                l3_rst_n_o,
    output logic                misc_rst_n_o,
    output logic                dbg_rst_n_o,
    output logic                mpu_rst_n_o,
    output logic [1:0]          cpu_clkoff_o,
    output logic [N_PERIPH-1:0] periph_rst_n_o,
    output logic                done_o
);
    localparam int unsigned MAX_AB  = (D_MISC > D_GATE) ? D_MISC : D_GATE;
    localparam int unsigned MAX_CD  = (D_MPU > D_UNGATE) ? D_MPU : D_UNGATE;
    localparam int unsigned MAX_D   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned CNT_W   = $clog2(MAX_D + 1);

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expire;
    logic             complete;

    rrs_stage_timer #(.CNT_W(CNT_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .expire_o   (expire)
    );

    rrs_ctrl #(
        .D_MISC   (D_MISC),
        .D_GATE   (D_GATE),
        .D_MPU    (D_MPU),
        .D_UNGATE (D_UNGATE),
        .CNT_W    (CNT_W)
    ) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cold_i       (cold_i),
        .expire_i     (expire),
        .load_o       (load),
        .load_val_o   (load_val),
        .l3_rst_n_o   (l3_rst_n_o),
        .misc_rst_n_o (misc_rst_n_o),
        .dbg_rst_n_o  (dbg_rst_n_o),
        .mpu_rst_n_o  (mpu_rst_n_o),
        .cpu_clkoff_o (cpu_clkoff_o),
        .done_o       (done_o),
        .complete_o   (complete)
    );

    rrs_periph_gate #(.N_PERIPH(N_PERIPH)) i_pgate (
        .complete_i (complete),
        .rel_i      (periph_rel_i),
        .rst_n_o    (periph_rst_n_o)
    );
endmodule

// File: rtl/rst_release_seq_chk.sv
// Property checker for the reset release sequencer, bound to the top.
// Assumes: the bound instance uses the top's port names.
module rst_release_seq_chk #(
    parameter int unsigned N_PERIPH = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_PERIPH-1:0] periph_rel_i,
    input logic                l3_rst_n_o,
    input logic                misc_rst_n_o,
    input logic                mpu_rst_n_o,
    input logic [1:0]          cpu_clkoff_o,
    input logic [N_PERIPH-1:0] periph_rst_n_o,
    input logic                done_o
);
    // R11
    clkoff_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clkoff_o[0] == cpu_clkoff_o[1]);

    // R7
    mpu_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mpu_rst_n_o) |-> cpu_clkoff_o == 2'b11);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_ungated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cpu_clkoff_o == 2'b00) && mpu_rst_n_o && misc_rst_n_o);

    // R9
    periph_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_rst_n_o & ~periph_rel_i) == '0);

    // R3
    misc_after_l3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misc_rst_n_o |-> l3_rst_n_o);

    // R6
    gate_after_misc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clkoff_o != 2'b00) |-> misc_rst_n_o);
endmodule

bind rst_release_seq rst_release_seq_chk #(.N_PERIPH(N_PERIPH)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .periph_rel_i   (periph_rel_i),
    .l3_rst_n_o     (l3_rst_n_o),
    .misc_rst_n_o   (misc_rst_n_o),
    .mpu_rst_n_o    (mpu_rst_n_o),
    .cpu_clkoff_o   (cpu_clkoff_o),
    .periph_rst_n_o (periph_rst_n_o),
    .done_o         (done_o)
);

// File: tb/test_rst_release_seq.sv
// Scoreboard bench: the driver queues expected output snapshots keyed by cycle,
// and the monitor compares them on the falling edge.
module test_rst_release_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    typedef struct {
        int          cyc;
        logic [10:0] val;
        string       req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          cold_i = 1'b0;
    logic [NP-1:0] periph_rel_i = '0;
    logic          l3_rst_n_o, misc_rst_n_o, dbg_rst_n_o, mpu_rst_n_o, done_o;
    logic [1:0]    cpu_clkoff_o;
    logic [NP-1:0] periph_rst_n_o;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    exp_t q[$];
    exp_t item;
    logic prev_dbg = 1'b0;
    logic [10:0] obs;

    rst_release_seq i_rst_release_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .cold_i         (cold_i),
        .periph_rel_i   (periph_rel_i),
        .l3_rst_n_o     (l3_rst_n_o),
        .misc_rst_n_o   (misc_rst_n_o),
        .dbg_rst_n_o    (dbg_rst_n_o),
        .mpu_rst_n_o    (mpu_rst_n_o),
        .cpu_clkoff_o   (cpu_clkoff_o),
        .periph_rst_n_o (periph_rst_n_o),
        .done_o         (done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign obs = {l3_rst_n_o, misc_rst_n_o, dbg_rst_n_o, mpu_rst_n_o,
                  cpu_clkoff_o, done_o, periph_rst_n_o};

    function automatic logic [10:0] mk(input logic l3, input logic misc,
            input logic dbg, input logic mpu, input logic [1:0] ck,
            input logic dn, input logic [3:0] pr);
        return {l3, misc, dbg, mpu, ck, dn, pr};
    endfunction

    task automatic push(input int c, input logic [10:0] v, input string r);
        exp_t e;
        e.cyc = c; e.val = v; e.req = r;
        q.push_back(e);
    endtask

    task automatic check(input string r, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b (cycle %0d)", r, act, exp, cyc);
        end
    endtask

    // Monitor: pop and compare every item due in this cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            item = q.pop_front();
            if (item.cyc != cyc) begin
                checks++; fails++;
                $display("FAIL %s: missed slot %0d at %0d expected %b", item.req, item.cyc, cyc, item.val);
            end else begin
                check(item.req, obs, item.val);
            end
        end
    end

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Driver: queue the expected timeline of one pass and drive its stimulus.
    task automatic run_pass(input logic cold, input logic [3:0] rel,
                            input bit mid_start, input bit end_start);
        int   c;
        logic d_pre, d_post;
        @(negedge clk);
        c = cyc;
        d_pre  = cold ? 1'b0 : prev_dbg;
        d_post = cold ? 1'b1 : prev_dbg;
        periph_rel_i = rel;
        push(c+1,   mk(1,0,d_pre,0,2'b00,0,4'h0), "R2");
        push(c+100, mk(1,0,d_pre,0,2'b00,0,4'h0), "R3");
        push(c+101, mk(1,1,d_post,0,2'b00,0,4'h0), cold ? "R4" : "R5");
        if (mid_start)
            push(c+152, mk(1,1,d_post,0,2'b00,0,4'h0), "R10");
        push(c+300, mk(1,1,d_post,0,2'b00,0,4'h0), "R6");
        push(c+301, mk(1,1,d_post,0,2'b11,0,4'h0), "R6");
        push(c+332, mk(1,1,d_post,0,2'b11,0,4'h0), "R7");
        push(c+333, mk(1,1,d_post,1,2'b11,0,4'h0), "R7");
        push(c+364, mk(1,1,d_post,1,2'b11,0,4'h0), "R8");
        push(c+365, mk(1,1,d_post,1,2'b00,1,rel), "R9");
        push(c+366, mk(1,1,d_post,1,2'b00,0,rel), end_start ? "R10" : "R8");
        if (end_start)
            push(c+370, mk(1,1,d_post,1,2'b00,0,rel), "R10");
        start_i = 1'b1;
        cold_i  = cold;
        @(negedge clk);
        start_i = 1'b0;
        if (mid_start) begin
            wait_cyc(c+150);
            start_i = 1'b1; cold_i = ~cold;
            @(negedge clk);
            start_i = 1'b0;
        end
        if (end_start) begin
            wait_cyc(c+364);
            start_i = 1'b1; cold_i = ~cold;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_cyc(c+372);
        prev_dbg = d_post;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, release bits set but ignored
        periph_rel_i = 4'hF;
        #1 check("R1", obs, mk(0,0,0,0,2'b00,0,4'h0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", obs, mk(0,0,0,0,2'b00,0,4'h0));
        // R5: warm pass from power-up, debug stays held
        run_pass(1'b0, 4'b0011, 1'b0, 1'b0);
        // R4: cold pass frees debug
        run_pass(1'b1, 4'b0101, 1'b0, 1'b0);
        // R9: release bits act combinationally after completion
        periph_rel_i = 4'b1111;
        #1 check("R9", {7'b0, periph_rst_n_o}, {7'b0, 4'b1111});
        periph_rel_i = 4'b0000;
        #1 check("R9", {7'b0, periph_rst_n_o}, {7'b0, 4'b0000});
        // R10: warm pass, debug stays freed, starts mid-pass and at the final edge
        run_pass(1'b0, 4'b1010, 1'b1, 1'b1);
        // R2: a new cold pass pulls the released peripherals back into reset
        run_pass(1'b1, 4'b1001, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        if (q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R8: %0d expected items left, expected 0", q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(CLK_PERIOD * 20000);
        checks++; fails++;
        $display("FAIL R10: watchdog expired at cycle %0d, expected end by 20000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule